// File: doc/BRIEF.md
# Frequency Strap Capture and Code Select

This block records the levels on four shared frequency-select pins while the power-on reset is held. Once reset lifts, it hands those pins over to their clock-output role and keeps the recorded levels for the rest of the power cycle. Every system clock it forms the active 4-bit frequency code. The code comes from the recorded straps, or from a code field in configuration byte 0 when that byte's override bit is set. From the code it derives the PCI divide ratio.

The same byte also carries the spread-spectrum enable, the spread-width choice and a request to tristate all clock outputs. These are registered and presented as plain control flags. The recorded strap levels are also offered for readback in inverted form, as a software view of the board strapping.

All outputs are plain control levels; no data stream crosses the block, so it has no handshake.

Top module: `fsel_top`

## Requirements
- R1: While `por_n` is low, each rising clock edge copies `strap_in` into the strap latch and into `freq_code`. During that time `strap_oe`, `spread_en`, `spread_wide` and `tristate_all` are 0.
- R2: `strap_oe` is 1 from the first rising edge at which `por_n` is high, and it returns to 0 only with the next reset.
- R3: After reset ends, the strap latch keeps its value. Later changes on `strap_in` have no effect on `strap_rb_n` or `freq_code`.
- R4: `strap_rb_n` equals the bitwise inverse of the latched strap levels.
- R5: With `por_n` high and `cfg_byte[3]` = 0, `freq_code` takes the latched strap code at the next rising edge.
- R6: With `por_n` high and `cfg_byte[3]` = 1, `freq_code` takes `{cfg_byte[2], cfg_byte[6:4]}` at the next rising edge; `cfg_byte[2]` is the MSB.
- R7: `pci_div3` is 1 (PCI = CPU/3) when `freq_code[2:0]` is 0 to 4. It is 0 (PCI = CPU/2) when `freq_code[2:0]` is 5 to 7. `freq_code[3]` has no effect on it, and it changes in the same cycle as `freq_code`.
- R8: `spread_en` follows `cfg_byte[1]`, and `spread_wide` follows `cfg_byte[7]` (1 = ±0.5%, 0 = ±0.25%). Both are registered with one clock of latency.
- R9: `tristate_all` follows `cfg_byte[0]` with one clock of latency.
- R10: A change on `cfg_byte` is not visible on any output before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; strap sampling window |
| strap_in | input | 4 | Levels on the shared frequency-select pins |
| cfg_byte | input | 8 | Configuration byte 0 |
| freq_code | output | 4 | Active frequency code |
| pci_div3 | output | 1 | 1 = PCI at CPU/3, 0 = PCI at CPU/2 |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_wide | output | 1 | 1 = ±0.5% spread, 0 = ±0.25% |
| tristate_all | output | 1 | Tristate request for all clock outputs |
| strap_oe | output | 1 | 1 = shared pins driven as outputs |
| strap_rb_n | output | 4 | Inverted latched strap levels |

## Verification
Two events can land on the same edge: reset release, which freezes the strap latch and turns the pins to outputs, and a new value on the strap pins or on the override bit. The bench moves `strap_in` on the last reset cycle and again right after release. It then checks that the code and the readback hold the level sampled on the final reset edge, not the later one. It also changes the override selection in the first cycle after release, and checks that the code swaps from the strap value to the register field on exactly the following edge.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int CODE_W     = 4;
  localparam int CFG_W      = 8;
  // byte 0 field positions
  localparam int B_TRI      = 0;
  localparam int B_SPREAD   = 1;
  localparam int B_CODE_MSB = 2;
  localparam int B_OVERRIDE = 3;
  localparam int B_CODE_LO  = 4;
  localparam int B_WIDE     = 7;

  typedef struct packed {
    logic spread_en;
    logic spread_wide;
    logic tristate_all;
  } ctrl_flags_t;
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsel_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] latched,
  output logic         pin_oe
);
  always_ff @(posedge clk) begin
    if (!por_n) begin
      latched <= pins;
      pin_oe  <= 1'b0;
    end else begin
      pin_oe  <= 1'b1;
    end
  end
endmodule

// File: rtl/fsel_code_mux.sv
module fsel_code_mux
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic [CODE_W-1:0] strap_lat,
  input  logic [CODE_W-1:0] strap_pins,
  input  logic [CFG_W-1:0]  cfg,
  output logic [CODE_W-1:0] code_d,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] reg_code;

  assign reg_code = {cfg[B_CODE_MSB], cfg[B_CODE_LO +: CODE_W-1]};

  always_comb begin
    if (!por_n)                 code_d = strap_pins;
    else if (cfg[B_OVERRIDE])   code_d = reg_code;
    else                        code_d = strap_lat;
  end

  always_ff @(posedge clk) code_q <= code_d;
endmodule

// File: rtl/fsel_ratio_dec.sv
module fsel_ratio_dec
  import fsel_pkg::*;
#(
  parameter int DIV3_MAX = 4
) (
  input  logic              clk,
  input  logic [CODE_W-1:0] code_d,
  output logic              div3_q
);
  localparam int LOW_W = CODE_W - 1;
  localparam logic [LOW_W-1:0] LIMIT = LOW_W'(DIV3_MAX);

  always_ff @(posedge clk) div3_q <= (code_d[LOW_W-1:0] <= LIMIT);
endmodule

// File: rtl/fsel_ctrl_flags.sv
module fsel_ctrl_flags
  import fsel_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic [CFG_W-1:0] cfg,
  output ctrl_flags_t      flags
);
  always_ff @(posedge clk) begin
    if (!por_n) begin
      flags <= '0;
    end else begin
      flags.spread_en    <= cfg[B_SPREAD];
      flags.spread_wide  <= cfg[B_WIDE];
      flags.tristate_all <= cfg[B_TRI];
    end
  end
endmodule

// File: rtl/fsel_top.sv
module fsel_top
  import fsel_pkg::*;
#(
  parameter int DIV3_MAX = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [CODE_W-1:0] strap_in,
  input  logic [CFG_W-1:0]  cfg_byte,
  output logic [CODE_W-1:0] freq_code,
  output logic              pci_div3,
  output logic              spread_en,
  output logic              spread_wide,
  output logic              tristate_all,
  output logic              strap_oe,
  output logic [CODE_W-1:0] strap_rb_n
);
  logic [CODE_W-1:0] strap_lat;
  logic [CODE_W-1:0] code_next;
  ctrl_flags_t       flags;

  fsel_strap_latch #(.W(CODE_W)) u_latch (
    .clk(clk), .por_n(por_n), .pins(strap_in),
    .latched(strap_lat), .pin_oe(strap_oe)
  );

  fsel_code_mux u_mux (
    .clk(clk), .por_n(por_n), .strap_lat(strap_lat), .strap_pins(strap_in),
    .cfg(cfg_byte), .code_d(code_next), .code_q(freq_code)
  );

  fsel_ratio_dec #(.DIV3_MAX(DIV3_MAX)) u_ratio (
    .clk(clk), .code_d(code_next), .div3_q(pci_div3)
  );

  fsel_ctrl_flags u_flags (
    .clk(clk), .por_n(por_n), .cfg(cfg_byte), .flags(flags)
  );

  assign spread_en    = flags.spread_en;
  assign spread_wide  = flags.spread_wide;
  assign tristate_all = flags.tristate_all;
  assign strap_rb_n   = ~strap_lat;
endmodule

// File: rtl/fsel_top_chk.sv
module fsel_top_chk (
  input logic       clk,
  input logic       por_n,
  input logic [7:0] cfg_byte,
  input logic [3:0] freq_code,
  input logic       pci_div3,
  input logic       tristate_all,
  input logic       spread_en,
  input logic       strap_oe,
  input logic [3:0] strap_rb_n
);
  // R2
  oe_after_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> strap_oe);
  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(strap_rb_n));
  // R5
  strap_select_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && !$past(cfg_byte[3])) |-> (freq_code == ~strap_rb_n));
  // R6
  reg_select_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && $past(cfg_byte[3])) |->
      (freq_code == {$past(cfg_byte[2]), $past(cfg_byte[6:4])}));
  // R7
  ratio_align_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> (pci_div3 == (freq_code[2:0] < 3'd5)));
  // R9
  tristate_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> (tristate_all == $past(cfg_byte[0])));
  // R8
  spread_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> (spread_en == $past(cfg_byte[1])));
endmodule

bind fsel_top fsel_top_chk u_chk (
  .clk(clk), .por_n(por_n), .cfg_byte(cfg_byte), .freq_code(freq_code),
  .pci_div3(pci_div3), .tristate_all(tristate_all), .spread_en(spread_en),
  .strap_oe(strap_oe), .strap_rb_n(strap_rb_n)
);

// File: tb/fsel_top_bench.sv
module fsel_top_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // {cfg[7:0], code[3:0], div3, spread_en, spread_wide, tristate}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 4'h6, 4'b0000},
    {8'h08, 4'h0, 4'b1000},
    {8'h5C, 4'hD, 4'b0000},
    {8'h2E, 4'hA, 4'b1100},
    {8'h83, 4'h6, 4'b0111},
    {8'hF9, 4'h7, 4'b0011},
    {8'h4C, 4'hC, 4'b1000},
    {8'h1A, 4'h1, 4'b1100}
  };

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [3:0] strap_in = 4'h0;
  logic [7:0] cfg_byte = 8'h00;
  logic [3:0] freq_code, strap_rb_n;
  logic       pci_div3, spread_en, spread_wide, tristate_all, strap_oe;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsel_top u_fsel_top (
    .clk(clk), .por_n(por_n), .strap_in(strap_in), .cfg_byte(cfg_byte),
    .freq_code(freq_code), .pci_div3(pci_div3), .spread_en(spread_en),
    .spread_wide(spread_wide), .tristate_all(tristate_all),
    .strap_oe(strap_oe), .strap_rb_n(strap_rb_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_div3(input logic [3:0] c);
    case (c)
      4'd5, 4'd6, 4'd7, 4'd13, 4'd14, 4'd15: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1: sampling during reset
    strap_in = 4'h3; step();
    check("R1 code follows straps", {4'h0, freq_code}, 8'h03);
    check("R1 oe low", {7'h0, strap_oe}, 8'h00);
    check("R1 flags low", {5'h0, spread_en, spread_wide, tristate_all}, 8'h00);
    cfg_byte = 8'h8B;
    strap_in = 4'h6; step();
    check("R1 readback during reset", {4'h0, strap_rb_n}, 8'h09);
    check("R1 flags ignore cfg", {5'h0, spread_en, spread_wide, tristate_all}, 8'h00);
    // release; pins move right after
    por_n = 1'b1; cfg_byte = 8'h00;
    step();
    strap_in = 4'hF;
    check("R2 oe high", {7'h0, strap_oe}, 8'h01);
    check("R4 readback", {4'h0, strap_rb_n}, 8'h09);
    check("R5 strap code", {4'h0, freq_code}, 8'h06);
    check("R7 div after release", {7'h0, pci_div3}, {7'h0, exp_div3(4'h6)});
    // R6 override at first cycle after release
    cfg_byte = 8'h2E; step();
    check("R6 override", {4'h0, freq_code}, 8'h0A);
    check("R3 readback held", {4'h0, strap_rb_n}, 8'h09);
    // vector table
    for (int i = 0; i < NVEC; i++) begin
      cfg_byte = VEC[i][15:8];
      step();
      check("R5/R6 code", {4'h0, freq_code}, {4'h0, VEC[i][7:4]});
      check("R7 div3", {7'h0, pci_div3}, {7'h0, VEC[i][3]});
      check("R7 div3 model", {7'h0, pci_div3}, {7'h0, exp_div3(VEC[i][7:4])});
      check("R8 spread", {6'h0, spread_en, spread_wide}, {6'h0, VEC[i][2:1]});
      check("R9 tristate", {7'h0, tristate_all}, {7'h0, VEC[i][0]});
      check("R2 oe stays", {7'h0, strap_oe}, 8'h01);
    end
    // R3: pin changes ignored
    cfg_byte = 8'h00;
    strap_in = 4'h1; step();
    strap_in = 4'hC; step();
    check("R3 code ignores pins", {4'h0, freq_code}, 8'h06);
    check("R3 readback ignores pins", {4'h0, strap_rb_n}, 8'h09);
    // R10: no change before the edge
    cfg_byte = 8'h5D; #1;
    check("R10 code before edge", {4'h0, freq_code}, 8'h06);
    check("R10 tristate before edge", {7'h0, tristate_all}, 8'h00);
    step();
    check("R10 code after edge", {4'h0, freq_code}, 8'h0D);
    check("R10 tristate after edge", {7'h0, tristate_all}, 8'h01);
    // second reset with new straps
    por_n = 1'b0; strap_in = 4'hA; step();
    check("R2 oe drops in reset", {7'h0, strap_oe}, 8'h00);
    check("R1 flags cleared", {5'h0, spread_en, spread_wide, tristate_all}, 8'h00);
    por_n = 1'b1; cfg_byte = 8'h00; step();
    strap_in = 4'h5;
    check("R4 new readback", {4'h0, strap_rb_n}, 8'h05);
    check("R5 new strap code", {4'h0, freq_code}, 8'h0A);
    check("R7 code bit3 no effect", {7'h0, pci_div3}, 8'h01);
    step();
    check("R3 held after second reset", {4'h0, freq_code}, 8'h0A);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule